// File: doc/BRIEF.md
# DRAM Self-Refresh Sequencer

This block moves an asynchronous DRAM into self-refresh for battery-backed standby and brings it back out. While the block is idle, the strobes stay inactive and the block waits for a sleep request. When sleep is requested, it first runs a back-to-back burst of CAS-before-RAS (CBR) refresh cycles, one per row. It then opens a self-refresh cycle without delay. In that cycle CAS falls first and RAS then stays low. The block holds both strobes low for at least the activation threshold and keeps them low until a wake request arrives.

A wake request that arrives before the threshold is not acted on until the threshold has passed, so the array is never left inside the window where its behaviour is undefined. On exit, both strobes rise together. The block then keeps RAS high for the self-refresh precharge time and immediately runs a second full CBR burst. After that burst it raises a completion acknowledge, which it holds until the sleep request is withdrawn.

All timings are clock-cycle counts set by parameters. With a 50 MHz clock, the defaults give 4096 rows and a threshold of 5000 cycles (100 µs). Write enable stays high for the whole sequence, so every refresh cycle is a CBR cycle and never a write.

Top module: `dram_selfrefresh_seq`

## Requirements
- R1: During and straight after reset, ras_n, cas_n and we_n are high and sr_active and done_ack are low.
- R2: While sleep_req is low and no sequence is running, ras_n and cas_n stay high and wake_req has no effect.
- R3: Every falling edge of ras_n comes after cas_n has been low, with RAS still high, for exactly T_CSR cycles. we_n stays high at all times.
- R4: After sleep_req rises, exactly ROWS CBR cycles run before self-refresh. In each one RAS is low for exactly T_RAS cycles, and RAS and CAS are both high for at least T_RP and at most T_RP+1 cycles before the next CAS fall.
- R5: The self-refresh cycle's CAS fall comes no more than T_RP+1 high cycles after the last pre-burst RAS rise.
- R6: sr_active is high only while ras_n and cas_n are both low, and only after RAS has been low for at least SR_MIN_CYC cycles.
- R7: If wake_req is already high before the threshold is reached, exit is deferred: RAS stays low for exactly SR_MIN_CYC+1 cycles and sr_active is high for one cycle.
- R8: If wake_req rises E cycles after sr_active is first seen, RAS stays low for SR_MIN_CYC+1+E cycles and sr_active stays high for E+1 cycles.
- R9: On exit, ras_n and cas_n rise in the same cycle. RAS then stays high for at least T_RPS and at most T_RPS+1 cycles before the next CAS fall.
- R10: After exit, exactly ROWS further CBR cycles run, with the R4 timing. done_ack then rises with both strobes high, 2*ROWS+1 RAS pulses after the sleep request.
- R11: done_ack stays high and no new cycle starts for as long as sleep_req stays high. One cycle after sleep_req falls, done_ack is low.
- R12: Once started, the sequence runs to completion even if sleep_req falls during the pre-burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Level request to enter self-refresh |
| wake_req | input | 1 | Level request to leave self-refresh |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| we_n | output | 1 | Write enable to the DRAM, held high |
| sr_active | output | 1 | DRAM is in self-refresh and the threshold has passed |
| done_ack | output | 1 | Exit sequence and post-burst have finished |

## Verification
The hardest case to reach from the ports is a wake request that arrives early and so falls inside the undefined window. The bench raises wake_req together with sleep_req, so the request is already pending through the whole pre-burst and entry. It then measures the length of the RAS-low pulse for self-refresh. A sweep of late wake delays checks that the pulse length grows by exactly one cycle per cycle of delay. A further run withdraws sleep_req in the middle of the pre-burst to show that the sequence is committed once started.

// File: rtl/sr_seq_pkg.sv
// Shared types for the self-refresh sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package sr_seq_pkg;

    // Top-level sequence states, in the order they are visited.
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PRE_BURST,
        SQ_ENTER,
        SQ_HOLD,
        SQ_EXIT_PRE,
        SQ_POST_BURST,
        SQ_DONE
    } sq_state_t;

    // Phases of one CBR refresh cycle.
    typedef enum logic [1:0] {
        EP_IDLE,
        EP_LEAD,
        EP_LOW,
        EP_PRE
    } eng_phase_t;

endpackage

// File: rtl/sr_cbr_engine.sv
// One CAS-before-RAS refresh cycle per start pulse.
// What it does: drops CAS for T_CSR cycles, then drops RAS as well for
// T_RAS cycles, then holds both high for T_RP cycles. It pulses done in
// the last precharge cycle.
// Assumes: start is only sampled while idle; all parameters are >= 1.
module sr_cbr_engine
    import sr_seq_pkg::*;
#(
    parameter int T_CSR = 1,
    parameter int T_RAS = 3,
    parameter int T_RP  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ras_n,
    output logic cas_n,
    output logic done,
    output logic idle
);

    localparam int M1   = (T_CSR > T_RAS) ? T_CSR : T_RAS;
    localparam int EMAX = (M1 > T_RP) ? M1 : T_RP;
    localparam int EW   = $clog2(EMAX + 1);

    eng_phase_t     ph_q;
    logic [EW-1:0]  cnt_q;

    // Phase sequencing with a per-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= EP_IDLE;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                EP_IDLE: begin
                    cnt_q <= '0;
                    if (start) ph_q <= EP_LEAD;
                end
                EP_LEAD: begin
                    if (cnt_q == EW'(T_CSR - 1)) begin
                        ph_q  <= EP_LOW;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                EP_LOW: begin
                    if (cnt_q == EW'(T_RAS - 1)) begin
                        ph_q  <= EP_PRE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == EW'(T_RP - 1)) begin
                        ph_q  <= EP_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Strobe levels and status decoded from the phase register.
    always_comb begin
        cas_n = !(ph_q == EP_LEAD || ph_q == EP_LOW);
        ras_n = (ph_q != EP_LOW);
        idle  = (ph_q == EP_IDLE);
        done  = (ph_q == EP_PRE) && (cnt_q == EW'(T_RP - 1));
    end

endmodule

// File: rtl/sr_burst_counter.sv
// Counts completed refresh cycles within one burst.
// What it does: advances on inc and flags the last row of the burst.
// Assumes: clr is held whenever no burst is running.
module sr_burst_counter #(
    parameter int ROWS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int CW = (ROWS > 1) ? $clog2(ROWS) : 1;

    generate
        if (ROWS > 1) begin : g_count
            logic [CW-1:0] cnt_q;

            // Row count within the burst.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) cnt_q <= '0;
                else if (inc)      cnt_q <= cnt_q + 1'b1;
            end

            // Last-row decode.
            always_comb last = (cnt_q == CW'(ROWS - 1));
        end else begin : g_single
            // A single-row burst finishes on its first cycle.
            always_comb last = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/sr_hold_timer.sv
// Measures the time spent in self-refresh against the activation threshold.
// What it does: counts cycles while en is high and sets a sticky reached
// flag after SR_MIN_CYC cycles.
// Assumes: en drops between self-refresh periods to clear the count.
module sr_hold_timer #(
    parameter int SR_MIN_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic reached
);

    localparam int TW = $clog2(SR_MIN_CYC + 1);

    logic [TW-1:0] cnt_q;

    // Saturating count up to the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q   <= '0;
            reached <= 1'b0;
        end else if (!reached) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == TW'(SR_MIN_CYC - 1)) reached <= 1'b1;
        end
    end

endmodule

// File: rtl/dram_selfrefresh_seq.sv
// Self-refresh entry/exit sequencer.
// What it does: on sleep_req runs a full CBR burst, enters self-refresh,
// holds it until wake_req and past the threshold, precharges, runs a
// second full CBR burst, then acknowledges.
// Assumes: the block owns the DRAM strobes for the whole sequence; all
// timing parameters are clock-cycle counts >= 1.
module dram_selfrefresh_seq
    import sr_seq_pkg::*;
#(
    parameter int ROWS       = 4096,
    parameter int T_CSR      = 1,
    parameter int T_RAS      = 3,
    parameter int T_RP       = 2,
    parameter int SR_MIN_CYC = 5000,
    parameter int T_RPS      = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic wake_req,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic sr_active,
    output logic done_ack
);

    localparam int PH_MAX = (T_CSR > T_RPS) ? T_CSR : T_RPS;
    localparam int PW     = $clog2(PH_MAX + 1);

    sq_state_t      st_q, st_d;
    logic [PW-1:0]  ph_q;
    logic           in_burst;
    logic           eng_start, eng_ras_n, eng_cas_n, eng_done, eng_idle;
    logic           burst_last;
    logic           hold_reached;

    // Burst states share the refresh engine and the row counter.
    always_comb in_burst = (st_q == SQ_PRE_BURST) || (st_q == SQ_POST_BURST);
    always_comb eng_start = in_burst && eng_idle;

    sr_cbr_engine #(
        .T_CSR (T_CSR),
        .T_RAS (T_RAS),
        .T_RP  (T_RP)
    ) u_engine (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .ras_n (eng_ras_n),
        .cas_n (eng_cas_n),
        .done  (eng_done),
        .idle  (eng_idle)
    );

    sr_burst_counter #(
        .ROWS (ROWS)
    ) u_rows (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_burst),
        .inc   (in_burst && eng_done),
        .last  (burst_last)
    );

    sr_hold_timer #(
        .SR_MIN_CYC (SR_MIN_CYC)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (st_q == SQ_HOLD),
        .reached (hold_reached)
    );

    // Next-state selection for the sequence.
    always_comb begin
        st_d = st_q;
        case (st_q)
            SQ_IDLE:       if (sleep_req)                 st_d = SQ_PRE_BURST;
            SQ_PRE_BURST:  if (eng_done && burst_last)    st_d = SQ_ENTER;
            SQ_ENTER:      if (ph_q == PW'(T_CSR - 1))    st_d = SQ_HOLD;
            SQ_HOLD:       if (hold_reached && wake_req)  st_d = SQ_EXIT_PRE;
            SQ_EXIT_PRE:   if (ph_q == PW'(T_RPS - 1))    st_d = SQ_POST_BURST;
            SQ_POST_BURST: if (eng_done && burst_last)    st_d = SQ_DONE;
            SQ_DONE:       if (!sleep_req)                st_d = SQ_IDLE;
            default:                                      st_d = SQ_IDLE;
        endcase
    end

    // State register and phase counter for the entry and exit timers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SQ_IDLE;
            ph_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d != st_q)
                ph_q <= '0;
            else if (st_q == SQ_ENTER || st_q == SQ_EXIT_PRE)
                ph_q <= ph_q + 1'b1;
        end
    end

    // Strobe multiplexing: engine during bursts, own levels otherwise.
    always_comb begin
        ras_n = 1'b1;
        cas_n = 1'b1;
        case (st_q)
            SQ_PRE_BURST, SQ_POST_BURST: begin
                ras_n = eng_ras_n;
                cas_n = eng_cas_n;
            end
            SQ_ENTER: cas_n = 1'b0;
            SQ_HOLD: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            default: ;
        endcase
    end

    // Acknowledge outputs and the write enable, held high.
    always_comb begin
        we_n      = 1'b1;
        sr_active = (st_q == SQ_HOLD) && hold_reached;
        done_ack  = (st_q == SQ_DONE);
    end

endmodule

// File: rtl/sr_seq_checker.sv
// Protocol checker for the self-refresh sequencer, bound to the top.
// What it does: watches the strobes and acknowledges and measures the
// RAS-low and RAS-high runs with its own counters.
// Assumes: it is attached through the bind statement at the end of this file.
module sr_seq_checker #(
    parameter int T_RAS      = 3,
    parameter int SR_MIN_CYC = 5000,
    parameter int T_RPS      = 5
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic sr_active,
    input logic done_ack
);

    localparam int LMAX = SR_MIN_CYC + T_RAS + T_RPS + 4;
    localparam int LW   = $clog2(LMAX + 1);

    logic [LW-1:0] low_cnt, hi_cnt;
    logic          after_sr;

    // Run lengths of RAS low and RAS high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            hi_cnt  <= '0;
        end else begin
            low_cnt <= ras_n ? '0 : ((low_cnt == LW'(LMAX)) ? low_cnt : low_cnt + 1'b1);
            hi_cnt  <= !ras_n ? '0 : ((hi_cnt == LW'(LMAX)) ? hi_cnt : hi_cnt + 1'b1);
        end
    end

    // Marks the stretch between a self-refresh period and the next CAS fall.
    always_ff @(posedge clk) begin
        if (!rst_n)                     after_sr <= 1'b0;
        else if (sr_active)             after_sr <= 1'b1;
        else if (!cas_n)                after_sr <= 1'b0;
    end

    // R3: RAS only falls while CAS is already low.
    a_r3_cbr_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));

    // R4: a burst refresh RAS pulse lasts exactly T_RAS cycles.
    a_r4_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_n) && !$past(sr_active)) |-> (low_cnt == LW'(T_RAS)));

    // R6: self-refresh is only reported with both strobes low.
    a_r6_sr_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> (!ras_n && !cas_n));

    // R6: self-refresh is only reported once the threshold has passed.
    a_r6_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> (low_cnt >= LW'(SR_MIN_CYC)));

    // R9: both strobes rise together when self-refresh ends.
    a_r9_exit_together: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_active) |-> (ras_n && cas_n));

    // R9: the self-refresh precharge is honoured before the next cycle.
    a_r9_exit_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && after_sr) |-> (hi_cnt >= LW'(T_RPS)));

    // R11: completion is reported with the strobes idle, never during self-refresh.
    a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_ack |-> (ras_n && cas_n && !sr_active));

endmodule

bind dram_selfrefresh_seq sr_seq_checker #(
    .T_RAS      (T_RAS),
    .SR_MIN_CYC (SR_MIN_CYC),
    .T_RPS      (T_RPS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .sr_active (sr_active),
    .done_ack  (done_ack)
);

// File: tb/dram_selfrefresh_seq_tb.sv
// Bench: sweeps wake timing and sleep withdrawal over a small configuration.
module dram_selfrefresh_seq_tb;

    localparam int ROWS   = 4;
    localparam int T_CSR  = 2;
    localparam int T_RAS  = 3;
    localparam int T_RP   = 2;
    localparam int SR_MIN = 20;
    localparam int T_RPS  = 4;
    localparam int NP     = 2 * ROWS + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic wake_req = 1'b0;
    logic ras_n, cas_n, we_n, sr_active, done_ack;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // Monitor state.
    int pidx, low_run, lead_run, hi_run, sr_cycles, strobe_act;
    int lowlen [16];
    int lead   [16];
    int gap    [16];
    bit prev_ras = 1'b1, prev_cas = 1'b1, we_bad = 1'b0;

    dram_selfrefresh_seq #(
        .ROWS(ROWS), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP),
        .SR_MIN_CYC(SR_MIN), .T_RPS(T_RPS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .sr_active(sr_active), .done_ack(done_ack)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            chk(1'b0, "watchdog", cycles, 100000);
            finish_run();
        end
    end

    task automatic clear_mon();
        pidx = 0; low_run = 0; lead_run = 0; hi_run = 0;
        sr_cycles = 0; strobe_act = 0;
        for (int i = 0; i < 16; i++) begin
            lowlen[i] = 0; lead[i] = 0; gap[i] = 0;
        end
    endtask

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!we_n) we_bad = 1'b1;
            if (!ras_n || !cas_n) strobe_act++;
            if (sr_active) sr_cycles++;
            if (prev_cas && !cas_n && pidx < 16) gap[pidx] = hi_run;
            if (!ras_n) begin
                if (prev_ras && pidx < 16) lead[pidx] = lead_run;
                low_run++;
            end else if (!prev_ras) begin
                if (pidx < 16) lowlen[pidx] = low_run;
                pidx++;
                low_run = 0;
            end
            if (!cas_n && ras_n) lead_run++;
            else if (cas_n) lead_run = 0;
            if (ras_n && cas_n) hi_run = (!prev_ras) ? 1 : hi_run + 1;
        end
        prev_ras = ras_n;
        prev_cas = cas_n;
    end

    task automatic run_seq(input bit early, input int extra, input bit drop);
        int guard;
        int exp_low;
        clear_mon();
        sleep_req = 1'b1;
        wake_req  = early;
        if (drop) begin
            guard = 0;
            while (pidx < 1 && guard < 500) begin @(negedge clk); guard++; end
            sleep_req = 1'b0;
        end
        guard = 0;
        while (!sr_active && guard < 2000) begin @(negedge clk); guard++; end
        chk(sr_active, "R12 self-refresh reached", sr_active, 1);
        chk(pidx == ROWS, "R4 pre-burst pulse count", pidx, ROWS);
        if (!early) begin
            repeat (extra) @(negedge clk);
            chk(sr_active && !ras_n, "R8 held until wake", sr_active, 1);
            wake_req = 1'b1;
        end
        guard = 0;
        while (!done_ack && guard < 2000) begin @(negedge clk); guard++; end
        wake_req = 1'b0;
        chk(done_ack, "R10 done_ack raised", done_ack, 1);
        chk(pidx == NP, "R10 total pulse count", pidx, NP);
        chk(ras_n && cas_n, "R10 strobes idle at done", {ras_n, cas_n}, 3);
        exp_low = early ? SR_MIN + 1 : SR_MIN + 1 + extra;
        chk(lowlen[ROWS] == exp_low, early ? "R7 deferred wake RAS low" : "R8 late wake RAS low",
            lowlen[ROWS], exp_low);
        chk(sr_cycles == (early ? 1 : extra + 1), early ? "R7 sr_active width" : "R8 sr_active width",
            sr_cycles, early ? 1 : extra + 1);
        for (int k = 0; k < NP; k++) begin
            chk(lead[k] == T_CSR, "R3 CAS lead before RAS", lead[k], T_CSR);
            if (k != ROWS) chk(lowlen[k] == T_RAS, "R4 burst RAS width", lowlen[k], T_RAS);
            if (k >= 1 && k < ROWS)
                chk(gap[k] >= T_RP && gap[k] <= T_RP + 1, "R4 burst precharge", gap[k], T_RP + 1);
            if (k == ROWS)
                chk(gap[k] >= 1 && gap[k] <= T_RP + 1, "R5 entry follows burst", gap[k], T_RP + 1);
            if (k == ROWS + 1)
                chk(gap[k] >= T_RPS && gap[k] <= T_RPS + 1, "R9 exit precharge", gap[k], T_RPS + 1);
            if (k > ROWS + 1)
                chk(gap[k] >= T_RP && gap[k] <= T_RP + 1, "R10 post-burst precharge", gap[k], T_RP + 1);
        end
        if (!drop) begin
            repeat (30) @(negedge clk);
            chk(done_ack, "R11 done_ack held", done_ack, 1);
            chk(pidx == NP, "R11 no restart while sleep high", pidx, NP);
            sleep_req = 1'b0;
            @(negedge clk);
        end
        @(negedge clk);
        chk(!done_ack, "R11 done_ack released", done_ack, 0);
        chk(ras_n && cas_n, "R11 back to idle", {ras_n, cas_n}, 3);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
        chk(!sr_active && !done_ack, "R1 acks low in reset", {sr_active, done_ack}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ras_n && cas_n && !sr_active && !done_ack, "R1 state after reset",
            {ras_n, cas_n, sr_active, done_ack}, 12);
        clear_mon();
        for (int i = 0; i < 20; i++) begin
            wake_req = i[0];
            @(negedge clk);
        end
        wake_req = 1'b0;
        chk(strobe_act == 0, "R2 wake ignored in idle", strobe_act, 0);
        chk(!sr_active && !done_ack, "R2 no ack in idle", {sr_active, done_ack}, 0);
        run_seq(1'b1, 0, 1'b0);
        run_seq(1'b0, 0, 1'b0);
        run_seq(1'b0, 3, 1'b0);
        run_seq(1'b0, 7, 1'b0);
        run_seq(1'b1, 0, 1'b1);
        chk(!we_bad, "R3 we_n always high", we_bad, 0);
        finish_run();
    end

endmodule